// File: doc/BRIEF.md
# Audio Control Register Slave

This block is the control port of an audio switching and volume unit. It sits on a two-wire serial bus as a target. A host first writes the device address with the direction bit clear. It then sends subaddress/data byte pairs, and each data byte lands in the control register that its subaddress names. All control registers are presented in parallel on a flat output vector, so the audio path logic downstream can decode them.

A read is a separate telegram. It starts with its own start condition and the address with the direction bit set. The block answers with a status byte that carries the identification decoder result and a clip flag. The clip flag is sticky: it holds once set and clears itself when a read captures it. A clip event that arrives while a read is shifting is kept for the next read.

The bus lines are oversampled by the system clock, which must run at least 16 times faster than the bus clock. Each line passes through a two-stage synchronizer, and SDA is pulled low through an output enable.

Top module: `audio_ctl_slave`

## Requirements
- R1: After reset every control register reads 0x00 on `regs_o` and `sda_oe_o` is low.
- R2: The address byte 0x84 (bits 7:1 = 1000010, bit 0 = 0 meaning write) is acknowledged by pulling SDA low during the ninth clock. Any other address is not acknowledged, and all bytes up to the next start get no acknowledge and change no register.
- R3: In a write telegram, the first byte after the address is a subaddress and the next byte is data. The data byte is stored in register k = subaddress, shown at `regs_o[8k+7:8k]`, before the next SCL rise after its acknowledge. No register changes without such a data byte.
- R4: Bytes alternate strictly between subaddress and data. In the telegram 03, 08, 09, 0A the value 08 is stored in register 3, 09 is taken as a subaddress, and 0A is therefore not written to register 3.
- R5: One write telegram may hold any number of pairs with any mix of subaddresses, and each pair updates its own register.
- R6: Every byte after a matching write address is acknowledged, including a subaddress above 0x07. The data byte that follows such a subaddress is acknowledged and discarded.
- R7: The address byte 0x85 is acknowledged and followed by the status byte, sent MSB first. Bits 7:6 carry `id_state_i` (00 mono, 01 stereo, 10 dual, 11 inhibited), bit 3 carries the clip flag, and all other bits are 0. After a master acknowledge, a freshly captured status byte follows. After a master no-acknowledge, SDA stays released.
- R8: A pulse on `clip_evt_i` sets the clip flag, and the flag stays set until a status byte captures it. The next status byte after that shows bit 3 = 0, unless a new event has occurred.
- R9: A clip event that arrives after the status byte has been captured, while it is still shifting out, is not lost. It is reported on the next read.
- R10: A stop condition releases SDA and ends the telegram. A telegram stopped after a subaddress writes nothing. A repeated start makes the first byte after the address a subaddress again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 16x the bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Raw serial clock line |
| sda_i | input | 1 | Raw serial data line (resolved bus level) |
| sda_oe_o | output | 1 | When high, pull SDA low |
| id_state_i | input | 2 | Identification decoder result: 00 mono, 01 stereo, 10 dual, 11 inhibited |
| clip_evt_i | input | 1 | One-cycle pulse when the speaker path clips |
| regs_o | output | 64 | Control registers, register k at bits 8k+7:8k |

## Verification
If the pair-alternation flag is wrong, data bytes are taken as subaddresses, or the reverse. The registers on `regs_o` then show wrong or missing values within a few system clocks of the byte's acknowledge. If the link sequencer state is wrong, it shows on SDA as a missing, extra or misplaced low during the ninth clock of the affected byte. If the clip flag is wrong, nothing shows until the next read, and the error appears in bit 3 of that status byte. For this reason the checks pair each clip stimulus with two reads in a row.

// File: rtl/audio_ctl_pkg.sv
package audio_ctl_pkg;

    localparam int unsigned BYTE_W      = 8;
    localparam logic [6:0]  DEV_ADDR7   = 7'b1000010;
    localparam int unsigned ST_ID_LSB   = 6;
    localparam int unsigned ST_CLIP_BIT = 3;

    typedef enum logic [2:0] {
        LK_IDLE  = 3'd0,
        LK_RX    = 3'd1,
        LK_ACK   = 3'd2,
        LK_TX    = 3'd3,
        LK_TXACK = 3'd4
    } link_st_e;

endpackage

// File: rtl/acs_bus_sync.sv
module acs_bus_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_o,
    output logic start_o,
    output logic stop_o,
    output logic rise_o,
    output logic fall_o
);

    typedef struct packed {
        logic [STAGES-1:0] scl_sh;
        logic [STAGES-1:0] sda_sh;
        logic              scl_p;
        logic              sda_p;
    } sync_t;

    sync_t q, d;
    logic  scl_s;

    always_comb begin
        d        = q;
        d.scl_sh = {q.scl_sh[STAGES-2:0], scl_i};
        d.sda_sh = {q.sda_sh[STAGES-2:0], sda_i};
        d.scl_p  = q.scl_sh[STAGES-1];
        d.sda_p  = q.sda_sh[STAGES-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '1;
        else        q <= d;
    end

    assign scl_s   = q.scl_sh[STAGES-1];
    assign sda_o   = q.sda_sh[STAGES-1];
    assign start_o = scl_s & q.scl_p & q.sda_p & ~sda_o;
    assign stop_o  = scl_s & q.scl_p & ~q.sda_p & sda_o;
    assign rise_o  = scl_s & ~q.scl_p;
    assign fall_o  = ~scl_s & q.scl_p;

endmodule

// File: rtl/acs_link.sv
module acs_link
    import audio_ctl_pkg::*;
#(
    parameter int unsigned NREG      = 8,
    parameter logic [6:0]  DEV_ADDR  = DEV_ADDR7,
    localparam int unsigned AW       = $clog2(NREG)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sda_s,
    input  logic              start_i,
    input  logic              stop_i,
    input  logic              rise_i,
    input  logic              fall_i,
    input  logic [BYTE_W-1:0] status_i,
    output logic              sda_oe_o,
    output logic              wr_en_o,
    output logic [AW-1:0]     wr_addr_o,
    output logic [BYTE_W-1:0] wr_data_o,
    output logic              rd_take_o
);

    typedef struct packed {
        link_st_e          state;
        logic [3:0]        bitcnt;
        logic [BYTE_W-1:0] shreg;
        logic              is_addr;
        logic              rd_mode;
        logic              want_sub;
        logic [BYTE_W-1:0] subaddr;
        logic              sda_oe;
        logic              more;
    } link_t;

    link_t q, d;
    logic  wr_en, rd_take;

    always_comb begin
        d       = q;
        wr_en   = 1'b0;
        rd_take = 1'b0;
        if (stop_i) begin
            d.state  = LK_IDLE;
            d.sda_oe = 1'b0;
        end else if (start_i) begin
            d.state    = LK_RX;
            d.is_addr  = 1'b1;
            d.bitcnt   = 4'd0;
            d.sda_oe   = 1'b0;
            d.want_sub = 1'b1;
        end else begin
            unique case (q.state)
                LK_RX: begin
                    if (rise_i && q.bitcnt < 4'd8) begin
                        d.shreg  = {q.shreg[BYTE_W-2:0], sda_s};
                        d.bitcnt = q.bitcnt + 4'd1;
                    end else if (fall_i && q.bitcnt == 4'd8) begin
                        if (q.is_addr) begin
                            if (q.shreg[7:1] == DEV_ADDR) begin
                                d.state   = LK_ACK;
                                d.sda_oe  = 1'b1;
                                d.rd_mode = q.shreg[0];
                            end else begin
                                d.state = LK_IDLE;
                            end
                        end else begin
                            d.state  = LK_ACK;
                            d.sda_oe = 1'b1;
                            if (q.want_sub) begin
                                d.subaddr  = q.shreg;
                                d.want_sub = 1'b0;
                            end else begin
                                d.want_sub = 1'b1;
                                wr_en      = (q.subaddr < BYTE_W'(NREG));
                            end
                        end
                    end
                end
                LK_ACK: begin
                    if (fall_i) begin
                        d.bitcnt  = 4'd0;
                        d.is_addr = 1'b0;
                        if (q.is_addr && q.rd_mode) begin
                            d.state  = LK_TX;
                            d.shreg  = status_i;
                            d.sda_oe = ~status_i[BYTE_W-1];
                            rd_take  = 1'b1;
                        end else begin
                            d.state  = LK_RX;
                            d.sda_oe = 1'b0;
                        end
                    end
                end
                LK_TX: begin
                    if (rise_i && q.bitcnt < 4'd8) begin
                        d.bitcnt = q.bitcnt + 4'd1;
                    end else if (fall_i) begin
                        if (q.bitcnt == 4'd8) begin
                            d.sda_oe = 1'b0;
                            d.state  = LK_TXACK;
                            d.more   = 1'b0;
                        end else begin
                            d.shreg  = {q.shreg[BYTE_W-2:0], 1'b0};
                            d.sda_oe = ~q.shreg[BYTE_W-2];
                        end
                    end
                end
                LK_TXACK: begin
                    if (rise_i) begin
                        if (sda_s) d.state = LK_IDLE;
                        else       d.more  = 1'b1;
                    end else if (fall_i && q.more) begin
                        d.state  = LK_TX;
                        d.bitcnt = 4'd0;
                        d.shreg  = status_i;
                        d.sda_oe = ~status_i[BYTE_W-1];
                        rd_take  = 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign sda_oe_o  = q.sda_oe;
    assign wr_en_o   = wr_en;
    assign wr_addr_o = q.subaddr[AW-1:0];
    assign wr_data_o = q.shreg;
    assign rd_take_o = rd_take;

    // R10
    stop_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stop_i |=> (q.state == LK_IDLE && !q.sda_oe));

    // R2
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q.state == LK_IDLE) |-> !sda_oe_o);

    // R6
    write_acked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en_o |=> (q.state == LK_ACK && sda_oe_o));

    // R7
    master_ack_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q.state == LK_TXACK) |-> !sda_oe_o);

endmodule

// File: rtl/acs_regfile.sv
module acs_regfile
    import audio_ctl_pkg::*;
#(
    parameter int unsigned NREG = 8,
    localparam int unsigned AW  = $clog2(NREG)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_en_i,
    input  logic [AW-1:0]            wr_addr_i,
    input  logic [BYTE_W-1:0]        wr_data_i,
    input  logic                     rd_take_i,
    input  logic                     clip_evt_i,
    input  logic [1:0]               id_state_i,
    output logic [BYTE_W-1:0]        status_o,
    output logic [NREG*BYTE_W-1:0]   regs_o
);

    typedef struct packed {
        logic [NREG-1:0][BYTE_W-1:0] regs;
        logic                        clip;
    } rf_t;

    rf_t q, d;

    always_comb begin
        d = q;
        if (wr_en_i) d.regs[wr_addr_i] = wr_data_i;
        d.clip = (q.clip & ~rd_take_i) | clip_evt_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    always_comb begin
        status_o                            = '0;
        status_o[ST_ID_LSB+1:ST_ID_LSB]     = id_state_i;
        status_o[ST_CLIP_BIT]               = q.clip;
    end

    generate
        for (genvar k = 0; k < NREG; k++) begin : g_out
            assign regs_o[k*BYTE_W +: BYTE_W] = q.regs[k];
        end
    endgenerate

    // R3
    regs_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en_i |=> $stable(q.regs));

    // R8
    clip_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clip_evt_i |=> q.clip);

    // R8
    clip_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_take_i && !clip_evt_i) |=> !q.clip);

endmodule

// File: rtl/audio_ctl_slave.sv
module audio_ctl_slave
    import audio_ctl_pkg::*;
#(
    parameter int unsigned NREG        = 8,
    parameter int unsigned SYNC_STAGES = 2,
    parameter logic [6:0]  DEV_ADDR    = DEV_ADDR7,
    localparam int unsigned AW         = $clog2(NREG)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   scl_i,
    input  logic                   sda_i,
    output logic                   sda_oe_o,
    input  logic [1:0]             id_state_i,
    input  logic                   clip_evt_i,
    output logic [NREG*BYTE_W-1:0] regs_o
);

    logic              sda_s, start_p, stop_p, rise_p, fall_p;
    logic              wr_en, rd_take;
    logic [AW-1:0]     wr_addr;
    logic [BYTE_W-1:0] wr_data, status;

    acs_bus_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .scl_i  (scl_i),
        .sda_i  (sda_i),
        .sda_o  (sda_s),
        .start_o(start_p),
        .stop_o (stop_p),
        .rise_o (rise_p),
        .fall_o (fall_p)
    );

    acs_link #(.NREG(NREG), .DEV_ADDR(DEV_ADDR)) u_link (
        .clk      (clk),
        .rst_n    (rst_n),
        .sda_s    (sda_s),
        .start_i  (start_p),
        .stop_i   (stop_p),
        .rise_i   (rise_p),
        .fall_i   (fall_p),
        .status_i (status),
        .sda_oe_o (sda_oe_o),
        .wr_en_o  (wr_en),
        .wr_addr_o(wr_addr),
        .wr_data_o(wr_data),
        .rd_take_o(rd_take)
    );

    acs_regfile #(.NREG(NREG)) u_rf (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en_i   (wr_en),
        .wr_addr_i (wr_addr),
        .wr_data_i (wr_data),
        .rd_take_i (rd_take),
        .clip_evt_i(clip_evt_i),
        .id_state_i(id_state_i),
        .status_o  (status),
        .regs_o    (regs_o)
    );

endmodule

// File: tb/audio_ctl_slave_bench.sv
module audio_ctl_slave_bench;

    localparam int Q = 20;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       scl_m = 1'b1;
    logic       sda_m = 1'b1;
    logic [1:0] id_st = 2'b00;
    logic       clip = 1'b0;
    logic       sda_oe;
    logic [63:0] regs;
    logic       sda_line;
    int         total = 0;
    int         bad = 0;
    logic [7:0] model [8];

    assign sda_line = sda_m & ~sda_oe;

    always #4 clk = ~clk;

    audio_ctl_slave u_audio_ctl_slave (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (scl_m),
        .sda_i     (sda_line),
        .sda_oe_o  (sda_oe),
        .id_state_i(id_st),
        .clip_evt_i(clip),
        .regs_o    (regs)
    );

    localparam logic [15:0] VEC [8] = '{16'h013F, 16'h022A, 16'h031F, 16'h0418,
                                        16'h0588, 16'h0610, 16'h07C8, 16'h0001};

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic w(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; w(Q); scl_m = 1'b1; w(Q); sda_m = 1'b0; w(Q); scl_m = 1'b0; w(Q);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; w(Q); scl_m = 1'b1; w(Q); sda_m = 1'b1; w(Q);
    endtask

    task automatic send_byte(input logic [7:0] b, output logic ack);
        for (int i = 7; i >= 0; i--) begin
            sda_m = b[i]; w(Q); scl_m = 1'b1; w(Q); scl_m = 1'b0; w(Q);
        end
        sda_m = 1'b1; w(Q); scl_m = 1'b1; w(Q/2);
        ack = ~sda_line;
        w(Q/2); scl_m = 1'b0; w(Q);
    endtask

    task automatic recv_byte(output logic [7:0] b, input logic mack);
        for (int i = 7; i >= 0; i--) begin
            sda_m = 1'b1; w(Q); scl_m = 1'b1; w(Q/2);
            b[i] = sda_line;
            w(Q/2); scl_m = 1'b0; w(Q);
        end
        sda_m = ~mack; w(Q); scl_m = 1'b1; w(Q); scl_m = 1'b0; w(Q);
        sda_m = 1'b1;
    endtask

    task automatic write_pair(input logic [7:0] sub, input logic [7:0] dat, input string req);
        logic a;
        bus_start();
        send_byte(8'h84, a); chk(req, {31'd0, a}, 32'd1);
        send_byte(sub, a);
        send_byte(dat, a);
        bus_stop();
    endtask

    task automatic pulse_clip();
        @(negedge clk) clip = 1'b1;
        @(negedge clk) clip = 1'b0;
    endtask

    task automatic read_status(output logic [7:0] b);
        logic a;
        bus_start();
        send_byte(8'h85, a); chk("R7 read address ack", {31'd0, a}, 32'd1);
        recv_byte(b, 1'b0);
        bus_stop();
    endtask

    task automatic check_all(input string req);
        for (int k = 0; k < 8; k++) chk(req, {24'd0, regs[k*8 +: 8]}, {24'd0, model[k]});
    endtask

    initial begin
        logic a;
        logic [7:0] b, b2;
        for (int k = 0; k < 8; k++) model[k] = 8'h00;
        w(5); rst_n = 1'b1; w(5);

        // R1: reset state
        check_all("R1 reset register");
        chk("R1 sda released", {31'd0, sda_oe}, 32'd0);

        // R3: table of single-pair telegrams
        for (int v = 0; v < 8; v++) begin
            write_pair(VEC[v][15:8], VEC[v][7:0], "R2 write address ack");
            model[VEC[v][10:8]] = VEC[v][7:0];
            chk("R3 stored byte", {24'd0, regs[VEC[v][10:8]*8 +: 8]}, {24'd0, VEC[v][7:0]});
        end

        // R5: several pairs in one telegram
        bus_start();
        send_byte(8'h84, a);
        send_byte(8'h01, a); send_byte(8'h05, a);
        send_byte(8'h02, a); send_byte(8'h06, a);
        send_byte(8'h03, a); send_byte(8'h00, a);
        bus_stop();
        model[1] = 8'h05; model[2] = 8'h06; model[3] = 8'h00;
        check_all("R5 mixed pairs");

        // R4: data repeated without subaddress
        bus_start();
        send_byte(8'h84, a);
        send_byte(8'h03, a); send_byte(8'h08, a);
        send_byte(8'h09, a); chk("R6 ack on out-of-range subaddress", {31'd0, a}, 32'd1);
        send_byte(8'h0A, a); chk("R6 ack on discarded data", {31'd0, a}, 32'd1);
        bus_stop();
        model[3] = 8'h08;
        check_all("R4 strict alternation");

        // R6: out-of-range subaddress discards data
        bus_start();
        send_byte(8'h84, a);
        send_byte(8'h20, a); chk("R6 ack subaddress 0x20", {31'd0, a}, 32'd1);
        send_byte(8'h77, a); chk("R6 ack data after 0x20", {31'd0, a}, 32'd1);
        bus_stop();
        check_all("R6 no register changed");

        // R2: foreign address
        bus_start();
        send_byte(8'hA4, a); chk("R2 foreign address nack", {31'd0, a}, 32'd0);
        send_byte(8'h03, a); chk("R2 ignored byte nack", {31'd0, a}, 32'd0);
        send_byte(8'h55, a); chk("R2 ignored byte nack", {31'd0, a}, 32'd0);
        bus_stop();
        check_all("R2 foreign telegram ignored");

        // R10: stop after subaddress; repeated start
        bus_start();
        send_byte(8'h84, a); send_byte(8'h02, a);
        bus_stop();
        check_all("R10 stop after subaddress");
        bus_start();
        send_byte(8'h84, a); send_byte(8'h06, a);
        bus_start();
        send_byte(8'h84, a); send_byte(8'h01, a); send_byte(8'h11, a);
        bus_stop();
        model[1] = 8'h11;
        check_all("R10 repeated start restarts pairing");
        chk("R10 sda released after stop", {31'd0, sda_oe}, 32'd0);

        // R7: status byte for every identification code
        for (int c = 0; c < 4; c++) begin
            id_st = c[1:0];
            read_status(b);
            chk("R7 status byte", {24'd0, b}, {24'd0, c[1:0], 6'd0});
        end
        id_st = 2'b01;

        // R8: sticky clip, cleared by read
        pulse_clip();
        w(50);
        read_status(b);
        chk("R8 clip reported", {24'd0, b}, 32'h48);
        read_status(b);
        chk("R8 clip cleared after read", {24'd0, b}, 32'h40);

        // R7/R8: two-byte read, second capture has clip cleared
        pulse_clip();
        bus_start();
        send_byte(8'h85, a);
        recv_byte(b, 1'b1);
        recv_byte(b2, 1'b0);
        bus_stop();
        chk("R7 first byte of two", {24'd0, b}, 32'h48);
        chk("R8 second byte clip cleared", {24'd0, b2}, 32'h40);

        // R9: event during shift is held
        bus_start();
        send_byte(8'h85, a);
        pulse_clip();
        recv_byte(b, 1'b0);
        bus_stop();
        chk("R9 capture before event", {24'd0, b}, 32'h40);
        read_status(b);
        chk("R9 held event reported", {24'd0, b}, 32'h48);
        chk("R7 sda released after nack", {31'd0, sda_oe}, 32'd0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule